// File: doc/BRIEF.md
# Non-Maskable Interrupt Source Controller

This block merges two active-low error inputs into a single non-maskable interrupt request for the processor. One input reports system errors raised by bus agents. The other reports I/O channel check events, meaning parity failures on add-in memory. Each input first passes through a two-flop synchronizer. It then sets a sticky detect flag. That flag stays set until software disarms the source. A master gate turns off the interrupt output as a whole. The gate never erases the detect flags, so an event latched while the gate was closed raises the interrupt as soon as the gate reopens.

Software reaches the block through a byte-wide I/O port with two decoded addresses:

- At the status address (0x61), software reads which sources are pending and writes per-source disarm bits.
- At the gate address (0x70), software writes the master disable in bit 7. Bits 6:0 of this register are an index field. It is stored and read back and has no other effect.

The interrupt output is a level. While any armed source is pending and the gate is open, the output stays high. A second event that arrives during that time therefore produces no new rising edge.

Top module: `nmi_ctrl`

## Requirements
- R1: After reset, a read of address 0x61 returns 0x0C, a read of address 0x70 returns 0x80, and `nmi_out` is low.
- R2: While bit 2 of 0x61 is 0, a low level on `sys_err_n` sets the system-error flag, read as bit 7 of 0x61, within three clock edges. The flag stays set after the input returns high.
- R3: While bit 3 of 0x61 is 0, a low level on `chan_chk_n` sets the channel-check flag, read as bit 6 of 0x61, within three clock edges. The flag stays set after the input returns high.
- R4: Writing 1 to bit 2 (system error) or bit 3 (channel check) of 0x61 clears that source's flag and holds it clear, even while its input is low. Writing 0 re-arms the source, which then sets only on a fresh low input.
- R5: `nmi_out` is high exactly when bit 7 of 0x70 is 0 and at least one flag is set.
- R6: Setting bit 7 of 0x70 leaves both flags unchanged. A flag latched while the gate is closed drives `nmi_out` high once bit 7 is written back to 0.
- R7: Bits 6:0 of 0x70 read back as written and have no effect on `nmi_out`.
- R8: Writes to bits 7:4 and 1:0 of 0x61 are ignored. Of those, bits 5:4 and 1:0 always read 0, and bits 7:6 read only the flags.
- R9: Reads of any address other than 0x61 and 0x70 return 0, and writes to them change no state.
- R10: While `nmi_out` is high, a second source becoming pending produces no new rising edge on `nmi_out`. Clearing one source while the other stays pending leaves `nmi_out` high without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_err_n | input | 1 | System error request, active low, asynchronous |
| chan_chk_n | input | 1 | I/O channel check request, active low, asynchronous |
| bus_addr | input | 8 | I/O address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| nmi_out | output | 1 | Non-maskable interrupt level |

## Verification
The inputs are driven in several patterns:

- An error that arrives while its source is disarmed must leave no trace.
- An error latched behind a closed gate must surface only when the gate reopens.
- A short pulse followed by release must leave the flag standing.
- Two overlapping sources must keep the output continuously high. A rising-edge counter on `nmi_out` tells a true level from a drop-and-reassert.

Writes of all ones to the status register, and traffic to an unused address, separate stored bits from ignored ones. Index writes with the gate open and no flags set show that the index field does not influence the interrupt.

// File: rtl/nmi_pkg.sv
// Package: shared constants for the NMI source controller.
// Assumes exactly two sources; index 0 is system error, index 1 is channel check.
package nmi_pkg;
    localparam int NMI_NSRC      = 2;
    localparam int NMI_DW        = 8;
    localparam int NMI_AW        = 8;
    localparam logic [NMI_AW-1:0] STAT_ADDR = 8'h61;
    localparam logic [NMI_AW-1:0] GATE_ADDR = 8'h70;
    localparam int GATE_BIT      = 7;
    localparam logic [NMI_DW-1:0] GATE_RESET = 8'h80;

    typedef enum int { SRC_SYSERR = 0, SRC_CHANCHK = 1 } nmi_src_e;

    // Read-only flag position in the status register for source i.
    function automatic int flag_pos(input int i);
        return 7 - i;
    endfunction

    // Active-low arm (disable) position in the status register for source i.
    function automatic int dis_pos(input int i);
        return 2 + i;
    endfunction
endpackage

// File: rtl/nmi_sync.sv
// Module: two-flop synchronizer bank for active-low asynchronous requests.
// Produces an active-high "request present" per bit. Assumes the inputs idle high,
// so the stages reset to 1 to avoid a false request out of reset.
module nmi_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_n,
    output logic [W-1:0] req_act
);
    logic [W-1:0] stg1_q;
    logic [W-1:0] stg2_q;

    // Shift the raw inputs through two capture stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg1_q <= '1;
            stg2_q <= '1;
        end else begin
            stg1_q <= req_n;
            stg2_q <= stg1_q;
        end
    end

    // Convert the synchronized low level to an active-high request.
    assign req_act = ~stg2_q;
endmodule

// File: rtl/nmi_detect.sv
// Module: sticky detect flop for one NMI source.
// Sets on a synchronized request while armed. While disarmed, the flop is cleared and held clear.
// Assumes req_act is already synchronous to clk.
module nmi_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic disarm,
    input  logic req_act,
    output logic flag
);
    logic flag_q;

    // Disarm wins; otherwise a request sets the flag and it holds.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (disarm)  flag_q <= 1'b0;
        else if (req_act) flag_q <= 1'b1;
    end

    assign flag = flag_q;
endmodule

// File: rtl/nmi_regfile.sv
// Module: I/O register file for the NMI controller.
// Decodes the status/control and gate/index addresses, stores the per-source disarm bits
// and the gate register, and returns read data combinationally. Writes are single-cycle strobes.
module nmi_regfile
    import nmi_pkg::*;
#(
    parameter int AW   = NMI_AW,
    parameter int DW   = NMI_DW,
    parameter int NSRC = NMI_NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [NSRC-1:0] flags,
    output logic [NSRC-1:0] src_dis,
    output logic            gate_off,
    output logic [DW-1:0]   bus_rdata
);
    logic           wr_stat;
    logic           wr_gate;
    logic [DW-1:0]  gate_q;
    logic [NSRC-1:0] dis_q;

    // Decode the two write targets.
    assign wr_stat = bus_wr && (bus_addr == STAT_ADDR);
    assign wr_gate = bus_wr && (bus_addr == GATE_ADDR);

    // One disarm bit per source, reset to disarmed.
    for (genvar i = 0; i < NSRC; i++) begin : g_dis
        always_ff @(posedge clk) begin
            if (!rst_n)       dis_q[i] <= 1'b1;
            else if (wr_stat) dis_q[i] <= bus_wdata[dis_pos(i)];
        end
    end

    // Gate register: bit 7 is the master disable, the rest is a stored index.
    always_ff @(posedge clk) begin
        if (!rst_n)       gate_q <= GATE_RESET;
        else if (wr_gate) gate_q <= bus_wdata;
    end

    assign src_dis  = dis_q;
    assign gate_off = gate_q[GATE_BIT];

    // Combinational read mux; unmapped addresses and bits return 0.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == STAT_ADDR) begin
            for (int i = 0; i < NSRC; i++) begin
                bus_rdata[flag_pos(i)] = flags[i];
                bus_rdata[dis_pos(i)]  = dis_q[i];
            end
        end else if (bus_addr == GATE_ADDR) begin
            bus_rdata = gate_q;
        end
    end
endmodule

// File: rtl/nmi_ctrl.sv
// Module: top level of the NMI source controller.
// Synchronizes the two active-low error inputs, latches each in a sticky detect flop,
// and drives a level NMI equal to the OR of the flags, gated by the master disable.
// Assumes a single clock domain for the bus; error inputs may be asynchronous.
module nmi_ctrl
    import nmi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_err_n,
    input  logic              chan_chk_n,
    input  logic [NMI_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NMI_DW-1:0] bus_wdata,
    output logic [NMI_DW-1:0] bus_rdata,
    output logic              nmi_out
);
    logic [NMI_NSRC-1:0] src_raw_n;
    logic [NMI_NSRC-1:0] src_act;
    logic [NMI_NSRC-1:0] src_dis;
    logic [NMI_NSRC-1:0] flag_q;
    logic                gate_off;

    // Gather the source inputs in source-index order.
    assign src_raw_n[SRC_SYSERR]  = sys_err_n;
    assign src_raw_n[SRC_CHANCHK] = chan_chk_n;

    nmi_sync #(.W(NMI_NSRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n   (src_raw_n),
        .req_act (src_act)
    );

    for (genvar i = 0; i < NMI_NSRC; i++) begin : g_src
        nmi_detect u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .disarm  (src_dis[i]),
            .req_act (src_act[i]),
            .flag    (flag_q[i])
        );
    end

    nmi_regfile #(.AW(NMI_AW), .DW(NMI_DW), .NSRC(NMI_NSRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .flags     (flag_q),
        .src_dis   (src_dis),
        .gate_off  (gate_off),
        .bus_rdata (bus_rdata)
    );

    // Level NMI: any pending flag while the master gate is open.
    assign nmi_out = !gate_off && (|flag_q);
endmodule

// File: rtl/nmi_ctrl_chk.sv
// Module: assertion checker for nmi_ctrl, attached by bind below.
// Observes the synchronized requests, the flags, the disarm bits, the gate and the output.
module nmi_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] act,
    input logic [1:0] flag,
    input logic [1:0] dis,
    input logic       gate_off,
    input logic       nmi
);
    AST_SERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[0] && !dis[0]) |=> flag[0]); // R2
    AST_SERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[0]) |-> $past(act[0])); // R2
    AST_CHK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[1] && !dis[1]) |=> flag[1]); // R3
    AST_CHK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[1]) |-> $past(act[1])); // R3
    AST_SERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dis[0] |=> !flag[0]); // R4
    AST_CHK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dis[1] |=> !flag[1]); // R4
    AST_RISE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi) |-> !gate_off); // R5
    AST_REOPEN_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_off) && (|flag)) |-> nmi); // R6
endmodule

bind nmi_ctrl nmi_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (src_act),
    .flag     (flag_q),
    .dis      (src_dis),
    .gate_off (gate_off),
    .nmi      (nmi_out)
);

// File: tb/nmi_ctrl_test.sv
// Scoreboard bench for nmi_ctrl: driver tasks queue expected items, a monitor
// compares them with the outputs shortly after the next rising edge.
module nmi_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_err_n = 1'b1;
    logic       chan_chk_n = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       nmi_out;

    int tests = 0;
    int fails = 0;
    int rises = 0;
    logic nmi_prev = 1'b0;
    bit done = 1'b0;

    typedef struct {
        bit         is_nmi;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    nmi_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_err_n  (sys_err_n),
        .chan_chk_n (chan_chk_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .nmi_out    (nmi_out)
    );

    // Monitor: pop one expected item per edge and compare.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                act = it.is_nmi ? {7'd0, nmi_out} : bus_rdata;
                tests++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: got %02h expected %02h", it.req, act, it.exp);
                end
            end
        end
    end

    // Count rising edges of the interrupt output after reset.
    always @(posedge clk) begin
        if (rst_n && nmi_out && !nmi_prev) rises++;
        nmi_prev <= rst_n ? nmi_out : 1'b0;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic exp_rd(input logic [7:0] a, input logic [7:0] e, input string req);
        @(negedge clk);
        bus_addr = a;
        sb.push_back('{1'b0, e, req});
        @(posedge clk);
        #3;
    endtask

    task automatic exp_nmi(input logic e, input string req);
        @(negedge clk);
        sb.push_back('{1'b1, {7'd0, e}, req});
        @(posedge clk);
        #3;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        exp_rd(8'h61, 8'h0C, "R1 status");
        exp_rd(8'h70, 8'h80, "R1 gate");
        exp_nmi(1'b0, "R1 nmi");
        // R4 disarmed source ignores a low input
        sys_err_n = 1'b0;
        idle(5);
        exp_rd(8'h61, 8'h0C, "R4 held clear");
        // R2 arm system error while input low; gate closed (R5)
        wr(8'h61, 8'h08);
        idle(4);
        exp_rd(8'h61, 8'h88, "R2 flag set");
        exp_nmi(1'b0, "R5 gate closed");
        sys_err_n = 1'b1;
        idle(4);
        exp_rd(8'h61, 8'h88, "R2 sticky");
        // R6 open gate with latched flag
        wr(8'h70, 8'h00);
        exp_nmi(1'b1, "R6 reopen fires");
        wr(8'h70, 8'hB5);
        exp_nmi(1'b0, "R5 gate off");
        exp_rd(8'h70, 8'hB5, "R7 index readback");
        exp_rd(8'h61, 8'h88, "R6 flag kept");
        wr(8'h70, 8'h35);
        exp_nmi(1'b1, "R5 gate on");
        exp_rd(8'h70, 8'h35, "R7 index readback open");
        // R3 second source while nmi already high (R10)
        wr(8'h61, 8'h00);
        chan_chk_n = 1'b0;
        idle(4);
        exp_rd(8'h61, 8'hC0, "R3 both flags");
        exp_nmi(1'b1, "R10 still high");
        chan_chk_n = 1'b1;
        // R4 clear one source, R10 other keeps nmi up
        wr(8'h61, 8'h04);
        idle(2);
        exp_rd(8'h61, 8'h44, "R4 serr cleared");
        exp_nmi(1'b1, "R10 no gap");
        // R8 all-ones write only touches disarm bits
        wr(8'h61, 8'hFF);
        idle(1);
        exp_rd(8'h61, 8'h0C, "R8 ignored bits");
        exp_nmi(1'b0, "R4 all cleared");
        // R4 re-arm with inputs high: no stale set
        wr(8'h61, 8'h00);
        idle(4);
        exp_rd(8'h61, 8'h00, "R4 rearm clean");
        // R7 index change with gate open and no flags
        wr(8'h70, 8'h7F);
        exp_nmi(1'b0, "R7 index no effect");
        exp_rd(8'h70, 8'h7F, "R7 full index");
        // R9 unmapped address
        wr(8'h62, 8'hFF);
        exp_rd(8'h62, 8'h00, "R9 unmapped read");
        exp_rd(8'h61, 8'h00, "R9 status untouched");
        exp_rd(8'h70, 8'h7F, "R9 gate untouched");
        // R10 edge count over the whole run
        idle(2);
        tests++;
        if (rises != 2) begin
            fails++;
            $display("FAIL R10 rising edges: got %0d expected %0d", rises, 2);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule